// File: doc/BRIEF.md
# Rotational Position and Latency Timer

This block keeps track of which word of a head-per-track disk track is passing under the heads. It models that angular position as a word counter that advances by one at the end of each programmable word time and wraps at the end of the track. The counter runs all the time, so the position can be read in status at any moment.

When the transfer engine asks to start at a given word, the block works out how many word times lie between the present angle and that word. It counts them down and then gives a single start pulse. After that pulse the same word-time ticks pace the transfer, one tick per word, until the engine ends the transfer. The word time is captured when a start is accepted. The pacing then stays fixed until the block is idle again.

Top module: `rot_latency_timer`

## Requirements
- R1: After reset, `pos_o` is 0, `status_o` is 0, and neither `go_o` nor `word_tick_o` is asserted.
- R2: `pos_o` advances by exactly one every N clocks, where N is the effective word time, and it goes from 2047 back to 0.
- R3: An `interval_i` value of 0 is treated as a word time of 1 clock.
- R4: For an accepted start, `go_o` pulses together with the rotation tick on which `pos_o` (before that tick) equals the target word. The number of whole words that pass between acceptance and that tick is (target − position) mod 2048, so a latency of zero gives the pulse on the very next tick.
- R5: `status_o[10:0]` mirrors `pos_o`, `status_o[16:11]` reads 0, and `status_o[17]` is 1 from the cycle after an accepted start until the block returns to idle.
- R6: `word_tick_o` is asserted once per word time while a transfer is active, which is from the cycle after `go_o` until stop. It is never asserted outside that window.
- R7: The word time is sampled when a start is accepted. Changes to `interval_i` while a start is pending or a transfer is active do not alter the spacing of the ticks.
- R8: `stop_i` returns the block to idle, drops a pending start so that no `go_o` follows, and clears the latency count. A stop in the same cycle as a start wins, and that start is dropped.
- R9: A start while a start is pending or a transfer is active is ignored, and the original target still decides when `go_o` fires.
- R10: `go_o` lasts exactly one clock and occurs at most once per accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| interval_i | input | 16 | Word time in clocks (0 treated as 1) |
| start_i | input | 1 | Start request strobe |
| stop_i | input | 1 | Cancel a pending start or end the active transfer |
| target_i | input | 11 | Requested word within the track |
| pos_o | output | 11 | Current rotational word position |
| status_o | output | 18 | Position in low bits, busy flag in bit 17 |
| go_o | output | 1 | One-clock start-transfer pulse |
| word_tick_o | output | 1 | Per-word pacing tick during a transfer |

## Verification
The bench aims at three latency cases. The first is a target equal to the current word: a design that started at once, or that waited a full turn, would report the wrong tick count. The second is a target just behind the heads, which needs 2047 words; a design that got the negative wrap of the subtraction wrong would fire early or never. The third is a target across the 2047-to-0 boundary. The bench changes `interval_i` in the middle of a transfer, which catches any design that paces from the live input instead of the sampled value. A stop is raised while a start is still pending, which catches a design that keeps its latency count and fires a stray start later. A second start is raised while one is pending, which catches a design that re-targets. A stop and a start are raised in the same cycle, which checks that the stop wins.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_WAIT = 2'd1,
    RS_XFER = 2'd2
  } rs_state_e;

endpackage

// File: rtl/rpt_rotor.sv
module rpt_rotor #(
  parameter int TRACK_WORDS = 2048,
  parameter int IVAL_W      = 16,
  parameter int POS_W       = $clog2(TRACK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IVAL_W-1:0] ival_i,
  output logic              tick_o,
  output logic [POS_W-1:0]  pos_q_o,
  output logic [POS_W-1:0]  pos_d_o
);

  localparam logic [POS_W-1:0] LAST_WORD = POS_W'(TRACK_WORDS - 1);

  logic [IVAL_W-1:0] cnt_q, cnt_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic              tick;

  // word time ends when the divider reaches interval-1 (interval never 0 here)
  always_comb begin
    tick  = (cnt_q >= (ival_i - IVAL_W'(1)));
    cnt_d = tick ? '0 : cnt_q + IVAL_W'(1);
    pos_d = pos_q;
    if (tick) begin
      pos_d = (pos_q == LAST_WORD) ? '0 : pos_q + POS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pos_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (tick) begin
        pos_q <= pos_d;
      end
    end
  end

  assign tick_o  = tick;
  assign pos_q_o = pos_q;
  assign pos_d_o = pos_d;

  a_r2_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pos_q == (($past(pos_q) == LAST_WORD) ? '0 : $past(pos_q) + POS_W'(1))));

  a_r2_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pos_q));

endmodule

// File: rtl/rpt_seq.sv
module rpt_seq
  import rpt_pkg::*;
#(
  parameter int TRACK_WORDS = 2048,
  parameter int IVAL_W      = 16,
  parameter int POS_W       = $clog2(TRACK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [POS_W-1:0]  target_i,
  input  logic [IVAL_W-1:0] ival_i,
  input  logic              tick_i,
  input  logic [POS_W-1:0]  pos_q_i,
  input  logic [POS_W-1:0]  pos_d_i,
  output logic [IVAL_W-1:0] ival_eff_o,
  output logic              go_o,
  output logic              word_tick_o,
  output logic              busy_o
);

  localparam logic [POS_W:0] TRACK_EXT = (POS_W+1)'(TRACK_WORDS);

  rs_state_e         state_q, state_d;
  logic [POS_W-1:0]  lat_q, lat_d;
  logic [POS_W-1:0]  tgt_q;
  logic [IVAL_W-1:0] ival_q;
  logic [IVAL_W-1:0] ival_live;
  logic [POS_W:0]    dist_w;
  logic              accept;
  logic              go_raw;

  // a zero word time is widened to one clock
  assign ival_live  = (ival_i == '0) ? IVAL_W'(1) : ival_i;
  assign ival_eff_o = (state_q == RS_IDLE) ? ival_live : ival_q;
  assign accept     = start_i && !stop_i && (state_q == RS_IDLE);

  // words between the position after this edge and the target, modulo track
  always_comb begin
    if (target_i >= pos_d_i) begin
      dist_w = {1'b0, target_i} - {1'b0, pos_d_i};
    end else begin
      dist_w = {1'b0, target_i} + TRACK_EXT - {1'b0, pos_d_i};
    end
  end

  always_comb begin
    state_d = state_q;
    lat_d   = lat_q;
    go_raw  = 1'b0;
    unique case (state_q)
      RS_IDLE: begin
        if (accept) begin
          state_d = RS_WAIT;
          lat_d   = dist_w[POS_W-1:0];
        end
      end
      RS_WAIT: begin
        if (tick_i) begin
          if (lat_q == '0) begin
            go_raw  = 1'b1;
            state_d = RS_XFER;
          end else begin
            lat_d = lat_q - POS_W'(1);
          end
        end
      end
      RS_XFER: begin
        state_d = RS_XFER;
      end
      default: begin
        state_d = RS_IDLE;
      end
    endcase
    if (stop_i) begin
      state_d = RS_IDLE;
      lat_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      lat_q   <= '0;
    end else begin
      state_q <= state_d;
      lat_q   <= lat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      ival_q <= '0;
    end else if (accept) begin
      tgt_q  <= target_i;
      ival_q <= ival_live;
    end
  end

  assign go_o        = go_raw && !stop_i;
  assign word_tick_o = (state_q == RS_XFER) && tick_i;
  assign busy_o      = (state_q != RS_IDLE);

  a_r4_go_at_target: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |-> (pos_q_i == tgt_q));

  a_r10_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |=> !go_o);

  a_r7_ival_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !stop_i) |=> $stable(ival_eff_o));

  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (state_q == RS_IDLE));

  a_r9_no_retarget: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(tgt_q));

endmodule

// File: rtl/rot_latency_timer.sv
module rot_latency_timer #(
  parameter int TRACK_WORDS = 2048,
  parameter int IVAL_W      = 16,
  parameter int STAT_W      = 18,
  parameter int POS_W       = $clog2(TRACK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IVAL_W-1:0] interval_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [POS_W-1:0]  target_i,
  output logic [POS_W-1:0]  pos_o,
  output logic [STAT_W-1:0] status_o,
  output logic              go_o,
  output logic              word_tick_o
);

  localparam int PAD_W = STAT_W - 1 - POS_W;

  logic [IVAL_W-1:0] ival_eff;
  logic              tick;
  logic [POS_W-1:0]  pos_q;
  logic [POS_W-1:0]  pos_d;
  logic              busy;

  rpt_rotor #(
    .TRACK_WORDS (TRACK_WORDS),
    .IVAL_W      (IVAL_W),
    .POS_W       (POS_W)
  ) u_rotor (
    .clk     (clk),
    .rst_n   (rst_n),
    .ival_i  (ival_eff),
    .tick_o  (tick),
    .pos_q_o (pos_q),
    .pos_d_o (pos_d)
  );

  rpt_seq #(
    .TRACK_WORDS (TRACK_WORDS),
    .IVAL_W      (IVAL_W),
    .POS_W       (POS_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .target_i    (target_i),
    .ival_i      (interval_i),
    .tick_i      (tick),
    .pos_q_i     (pos_q),
    .pos_d_i     (pos_d),
    .ival_eff_o  (ival_eff),
    .go_o        (go_o),
    .word_tick_o (word_tick_o),
    .busy_o      (busy)
  );

  assign pos_o    = pos_q;
  assign status_o = {busy, {PAD_W{1'b0}}, pos_q};

  a_r5_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |-> status_o[STAT_W-1]);

  a_r6_tick_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    word_tick_o |=> (pos_o != $past(pos_o)));

endmodule

// File: tb/tb_rot_latency_timer.sv
module tb_rot_latency_timer;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 2048;

  logic        clk;
  logic        rst_n;
  logic [15:0] interval_i;
  logic        start_i;
  logic        stop_i;
  logic [10:0] target_i;
  logic [10:0] pos_o;
  logic [17:0] status_o;
  logic        go_o;
  logic        word_tick_o;

  rot_latency_timer dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .interval_i  (interval_i),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .target_i    (target_i),
    .pos_o       (pos_o),
    .status_o    (status_o),
    .go_o        (go_o),
    .word_tick_o (word_tick_o)
  );

  typedef struct {
    int tgt;
    int lat;
    int stamp;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  int   gticks = 0;
  int   since  = 0;
  int   exp_n  = 10;
  int   skip   = 1;
  int   go_g   = 0;
  int   wt_cnt = 0;
  int   go_total = 0;
  bit   act    = 0;
  bit   prev_go = 0;
  bit   done   = 0;
  int   prev_pos = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // monitor: pops expected starts and checks outputs every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      since++;
      if (int'(pos_o) != prev_pos) begin
        chk("R2 step", int'(pos_o), (prev_pos + 1) % WORDS);
        if (skip > 0) skip--;
        else chk("R2/R3/R7 spacing", since, exp_n);
        since = 0;
        gticks++;
      end
      prev_pos = int'(pos_o);
      chk("R5 status low", int'(status_o[16:0]), int'(pos_o));
      if (word_tick_o && !act) chk("R6 tick outside transfer", 1, 0);
      if (word_tick_o) wt_cnt++;
      if (go_o) begin
        go_total++;
        if (prev_go) chk("R10 go width", 2, 1);
        chk("R5 busy at go", int'(status_o[17]), 1);
        if (q.size() == 0) begin
          chk("R8/R9 unexpected go", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R4 go target", int'(pos_o), e.tgt);
          chk("R4 latency words", gticks - e.stamp, e.lat);
        end
        act    = 1;
        go_g   = gticks;
        wt_cnt = 0;
      end
      prev_go = go_o;
    end
  end

  task automatic wait_step();
    int last;
    last = int'(pos_o);
    do begin
      @(negedge clk); #1;
    end while (int'(pos_o) == last);
  endtask

  task automatic do_start(input int off);
    exp_t e;
    wait_step();
    e.tgt   = (int'(pos_o) + off) % WORDS;
    e.lat   = off;
    e.stamp = gticks;
    q.push_back(e);
    target_i = 11'(e.tgt);
    start_i  = 1'b1;
    @(negedge clk); #1;
    start_i  = 1'b0;
  endtask

  task automatic wait_go();
    while (q.size() != 0) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic do_stop(input int new_n);
    wait_step();
    if (act) chk("R6 ticks per word", wt_cnt, gticks - go_g - 1);
    act = 0;
    q.delete();
    stop_i = 1'b1;
    @(negedge clk); #1;
    stop_i = 1'b0;
    exp_n = new_n;
    skip  = 2;
    @(negedge clk); #1;
    chk("R8 idle after stop", int'(status_o[17]), 0);
  endtask

  task automatic set_ival(input int v, input int n);
    interval_i = 16'(v);
    exp_n = n;
    skip  = 2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    interval_i = 16'd10;
    start_i = 1'b0;
    stop_i = 1'b0;
    target_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 pos", int'(pos_o), 0);
    chk("R1 status", int'(status_o), 0);
    chk("R1 go", int'(go_o), 0);
    chk("R1 tick", int'(word_tick_o), 0);
    #1 rst_n = 1'b1;
    repeat (45) @(negedge clk);

    // R3: zero word time acts as one clock; also cover the wrap for R2
    set_ival(0, 1);
    while (pos_o != 11'd2047) @(negedge clk);
    @(negedge clk);
    chk("R2 wrap", int'(pos_o), 0);
    #1 set_ival(2, 2);
    repeat (10) @(negedge clk);
    #1;

    // R4: zero latency, short latency, full-turn latency
    do_start(0);
    wait_go();
    repeat (6) @(negedge clk);
    #1 do_stop(2);
    do_start(5);
    wait_go();
    do_stop(2);
    do_start(2047);
    wait_go();
    do_stop(2);

    // R9 and R7: second start ignored, interval change mid transfer
    do_start(40);
    repeat (4) @(negedge clk);
    #1 target_i = 11'(int'(pos_o) + 3);
    start_i = 1'b1;
    @(negedge clk); #1 start_i = 1'b0;
    wait_go();
    interval_i = 16'd7;
    repeat (40) @(negedge clk);
    #1 do_stop(7);
    repeat (30) @(negedge clk);
    #1;

    // R8: cancel a pending start
    set_ival(3, 3);
    repeat (8) @(negedge clk);
    #1 do_start(100);
    repeat (20) @(negedge clk);
    #1 do_stop(3);
    go_total = 0;
    repeat (400) @(negedge clk);
    chk("R8 cancelled go count", go_total, 0);

    // R8: stop and start together, stop wins
    #1 target_i = pos_o;
    start_i = 1'b1;
    stop_i  = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
    stop_i  = 1'b0;
    @(negedge clk);
    chk("R8 stop beats start", int'(status_o[17]), 0);
    repeat (20) @(negedge clk);
    chk("R8 no go after clash", go_total, 0);
    chk("R4 queue drained", q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule